// File: doc/BRIEF.md
# Sliding Two-Column Window Sum Unit

This streaming unit produces the sum of all pixels in a window that is three rows tall and two columns wide, as the window slides one column to the right per step across an image of unsigned 8-bit pixels. An upstream line buffer delivers one vertical column of three pixels per beat, in row-major scan order. The unit adds up only that incoming column. The other half of the window is the column sum from the previous beat, which a register holds. As a result, each beat reads three pixels rather than six, and only one column adder is built.

The first beat of every row has no left neighbour. That beat only loads the register, and its output is marked invalid. A row starts either at an explicit start-of-row marker or when a runtime row length has been reached. A row of C columns therefore yields C-1 valid sums. For an R x C image, whose line buffer emits R-2 column rows, the unit yields (R-2) x (C-1) sums.

Top module: `colpair_sum_unit`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, sum_valid_o is 0 and sum_o is 0.
- R2: Pixel k of the column (k = 0 is the top row) occupies col_pix_i bits [8k+7:8k], and all three pixels are added as unsigned values.
- R3: For an accepted beat that is not a priming beat, sum_o in the next cycle equals the column sum of that beat plus the column sum of the previous accepted beat, and sum_valid_o is 1.
- R4: A beat with row_start_i = 1 is a priming beat: sum_valid_o is 0 in the next cycle, and its column sum becomes the left column for the following beat.
- R5: The first accepted beat after reset is a priming beat, with or without row_start_i.
- R6: When row_len_i is N > 0, the beat after N accepted beats of a row is a priming beat even without row_start_i. When row_len_i is 0, rows are delimited only by row_start_i.
- R7: In a cycle with col_valid_i = 0, sum_valid_o is 0 in the next cycle and sum_o holds its value. The stored left column is kept, so the next beat pairs with the last accepted column.
- R8: The full-scale window (six pixels of 255) gives sum_o = 1530 without wrapping.
- R9: A row of C accepted columns yields exactly C-1 valid outputs.
- R10: row_start_i in the middle of a row restarts the row at that beat, whatever the row position count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_valid_i | input | 1 | A column beat is present this cycle |
| row_start_i | input | 1 | This beat is the first column of a row |
| row_len_i | input | 12 | Columns per row; 0 disables automatic row wrap |
| col_pix_i | input | 24 | Three column pixels, top row in the low byte |
| sum_o | output | 11 | Two-column window sum |
| sum_valid_o | output | 1 | sum_o holds a real window result |

## Verification
The bench builds the unit with its defaults: 8-bit pixels, three-row columns and a 12-bit row length. This puts full-scale pixels within reach, so the 1530 ceiling can be exercised against the 11-bit output. Short row lengths such as 4 make automatic row wrap and the per-row count of valid outputs reachable within a few beats. Row length 0 keeps marker-only framing available, so idle gaps and mid-row restarts can be mixed with either framing.

// File: rtl/colpair_pkg.sv
`timescale 1ns/1ps
package colpair_pkg;
  typedef struct packed {
    logic take;   // beat accepted this cycle
    logic prime;  // beat only loads the left-column register
  } beat_t;
endpackage

// File: rtl/colpair_col_adder.sv
`timescale 1ns/1ps
module colpair_col_adder #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 3,
  localparam int CS_W = PIX_W + $clog2(ROWS)
) (
  input  logic [ROWS*PIX_W-1:0] col_i,
  output logic [CS_W-1:0]       sum_o
);
  logic [CS_W-1:0] part [ROWS+1];
  assign part[0] = '0;
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign part[g+1] = part[g] + CS_W'(col_i[g*PIX_W +: PIX_W]);
  end
  assign sum_o = part[ROWS];
endmodule

// File: rtl/colpair_prime_ctrl.sv
`timescale 1ns/1ps
module colpair_prime_ctrl
  import colpair_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             col_valid_i,
  input  logic             row_start_i,
  input  logic [COL_W-1:0] row_len_i,
  output beat_t            beat_o
);
  logic [COL_W-1:0] pos_q, pos_nxt;
  logic             first;

  // position 0 means the next beat opens a row
  assign first   = row_start_i || (pos_q == '0);
  assign pos_nxt = first ? COL_W'(1) : pos_q + COL_W'(1);

  assign beat_o.take  = col_valid_i;
  assign beat_o.prime = col_valid_i && first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (col_valid_i) begin
      if (row_len_i == '0)          pos_q <= COL_W'(1);
      else if (pos_nxt == row_len_i) pos_q <= '0;
      else                          pos_q <= pos_nxt;
    end
  end
endmodule

// File: rtl/colpair_window_acc.sv
`timescale 1ns/1ps
module colpair_window_acc
  import colpair_pkg::*;
#(
  parameter int CS_W = 10,
  localparam int SUM_W = CS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  beat_t            beat_i,
  input  logic [CS_W-1:0]  col_sum_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             sum_valid_o
);
  logic [CS_W-1:0]  left_q;
  logic [SUM_W-1:0] sum_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sum_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= beat_i.take && !beat_i.prime;
      if (beat_i.take) begin
        left_q <= col_sum_i;
        sum_q  <= SUM_W'(left_q) + SUM_W'(col_sum_i);
      end
    end
  end

  assign sum_o       = sum_q;
  assign sum_valid_o = vld_q;
endmodule

// File: rtl/colpair_sum_unit.sv
`timescale 1ns/1ps
module colpair_sum_unit
  import colpair_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ROWS  = 3,
  parameter int COL_W = 12,
  localparam int CS_W  = PIX_W + $clog2(ROWS),
  localparam int SUM_W = CS_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  col_valid_i,
  input  logic                  row_start_i,
  input  logic [COL_W-1:0]      row_len_i,
  input  logic [ROWS*PIX_W-1:0] col_pix_i,
  output logic [SUM_W-1:0]      sum_o,
  output logic                  sum_valid_o
);
  logic [CS_W-1:0] col_sum;
  beat_t           beat;

  colpair_col_adder #(.PIX_W(PIX_W), .ROWS(ROWS)) u_adder (
    .col_i (col_pix_i),
    .sum_o (col_sum)
  );

  colpair_prime_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .col_valid_i (col_valid_i),
    .row_start_i (row_start_i),
    .row_len_i   (row_len_i),
    .beat_o      (beat)
  );

  colpair_window_acc #(.CS_W(CS_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_i      (beat),
    .col_sum_i   (col_sum),
    .sum_o       (sum_o),
    .sum_valid_o (sum_valid_o)
  );
endmodule

// File: rtl/colpair_sum_chk.sv
`timescale 1ns/1ps
module colpair_sum_chk #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 3,
  parameter int COL_W = 12,
  localparam int CS_W  = PIX_W + $clog2(ROWS),
  localparam int SUM_W = CS_W + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  col_valid_i,
  input logic                  row_start_i,
  input logic [COL_W-1:0]      row_len_i,
  input logic [ROWS*PIX_W-1:0] col_pix_i,
  input logic [SUM_W-1:0]      sum_o,
  input logic                  sum_valid_o
);
  logic [CS_W-1:0] cs_now, ref_q;
  logic            seen_q;

  always_comb begin
    cs_now = '0;
    for (int k = 0; k < ROWS; k++) cs_now = cs_now + CS_W'(col_pix_i[k*PIX_W +: PIX_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      seen_q <= 1'b0;
    end else if (col_valid_i) begin
      ref_q  <= cs_now;
      seen_q <= 1'b1;
    end
  end

  always @(negedge clk_i) if (!rst_ni) begin
    AST_RESET_QUIET: assert (!sum_valid_o && sum_o == '0); // R1
  end

  AST_PAIR_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> sum_o == SUM_W'($past(ref_q)) + SUM_W'($past(cs_now))); // R3

  AST_PRIME_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_i && row_start_i) |=> !sum_valid_o); // R4

  AST_FIRST_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_i && !seen_q) |=> !sum_valid_o); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_valid_i |=> (!sum_valid_o && $stable(sum_o))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= SUM_W'(2 * ROWS * (2**PIX_W - 1))); // R8
endmodule

bind colpair_sum_unit colpair_sum_chk #(.PIX_W(PIX_W), .ROWS(ROWS), .COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .col_valid_i(col_valid_i), .row_start_i(row_start_i),
  .row_len_i(row_len_i), .col_pix_i(col_pix_i), .sum_o(sum_o), .sum_valid_o(sum_valid_o)
);

// File: tb/colpair_sum_unit_bench.sv
`timescale 1ns/1ps
module colpair_sum_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        col_valid_i = 1'b0;
  logic        row_start_i = 1'b0;
  logic [11:0] row_len_i = '0;
  logic [23:0] col_pix_i = '0;
  logic [10:0] sum_o;
  logic        sum_valid_o;

  int checks = 0;
  int fails  = 0;

  // bench model state, built from the requirements
  int m_pos = 0;
  int m_ref = 0;
  int m_sum = 0;
  int row_valids = 0;

  always #5 clk_i = ~clk_i;

  colpair_sum_unit u_colpair_sum_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .col_valid_i(col_valid_i), .row_start_i(row_start_i),
    .row_len_i(row_len_i), .col_pix_i(col_pix_i), .sum_o(sum_o), .sum_valid_o(sum_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive, let the edge pass, compare against the model
  task automatic step(input bit v, input bit rs, input int a, input int b, input int c,
                      input string tag);
    bit exp_v;
    int cs;
    @(negedge clk_i);
    col_valid_i = v;
    row_start_i = rs;
    col_pix_i   = {8'(c), 8'(b), 8'(a)};
    exp_v = 1'b0;
    if (v) begin
      bit first;
      cs    = a + b + c;
      first = rs || (m_pos == 0);
      if (row_len_i == 0) m_pos = 1;
      else begin
        m_pos = first ? 1 : m_pos + 1;
        if (m_pos == int'(row_len_i)) m_pos = 0;
      end
      m_sum = m_ref + cs;
      m_ref = cs;
      exp_v = !first;
    end
    @(posedge clk_i);
    #1;
    chk(sum_valid_o == exp_v, {tag, " valid"}, sum_valid_o, exp_v);
    chk(sum_o == 11'(m_sum), {tag, " sum"}, sum_o, m_sum);
    if (sum_valid_o) row_valids++;
    col_valid_i = 1'b0;
    row_start_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(sum_valid_o == 1'b0, "R1 valid in reset", sum_valid_o, 0);
    chk(sum_o == 11'd0, "R1 sum in reset", sum_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    chk(sum_valid_o == 1'b0, "R1 valid after release", sum_valid_o, 0);
  endtask

  task automatic t_basic;
    row_len_i = 12'd0;
    step(1, 0, 1, 2, 3, "R5 first beat primes");
    step(1, 0, 4, 5, 6, "R3 pair 6+15");
    chk(sum_o == 11'd21, "R2 literal 21", sum_o, 21);
    step(1, 0, 10, 20, 30, "R2 R3 pair 15+60");
    chk(sum_o == 11'd75, "R3 literal 75", sum_o, 75);
  endtask

  task automatic t_idle;
    step(0, 0, 99, 99, 99, "R7 idle 1");
    step(0, 1, 50, 50, 50, "R7 idle with marker");
    chk(sum_o == 11'd75, "R7 hold 75", sum_o, 75);
    step(1, 0, 1, 1, 1, "R7 pair across gap");
    chk(sum_o == 11'd63, "R7 literal 63", sum_o, 63);
  endtask

  task automatic t_restart;
    step(1, 0, 2, 2, 2, "R3 mid row");
    step(1, 1, 7, 7, 7, "R10 marker mid row");
    step(1, 0, 0, 0, 1, "R10 pair after restart");
    chk(sum_o == 11'd22, "R10 literal 22", sum_o, 22);
  endtask

  task automatic t_full_scale;
    step(1, 1, 255, 255, 255, "R4 prime full");
    step(1, 0, 255, 255, 255, "R8 full scale");
    chk(sum_o == 11'd1530, "R8 literal 1530", sum_o, 1530);
    step(1, 0, 0, 0, 0, "R8 drop to half");
  endtask

  task automatic t_row_len;
    step(0, 0, 0, 0, 0, "R6 idle before length change");
    row_len_i = 12'd4;
    for (int r = 0; r < 2; r++) begin
      row_valids = 0;
      for (int c = 0; c < 4; c++)
        step(1, (r == 0 && c == 0), 10 * r + c, c, 3, "R6 auto row");
      chk(row_valids == 3, "R9 valids per row", row_valids, 3);
    end
    step(1, 0, 5, 5, 5, "R6 wrap primes");
    chk(sum_valid_o == 1'b0, "R6 wrap beat masked", sum_valid_o, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    t_basic();
    t_idle();
    t_restart();
    t_full_scale();
    t_row_len();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule